// File: doc/BRIEF.md
# DDR SDRAM Command Legality Guard

The guard sits beside a controller's command bus to a four-bank DDR SDRAM device. It samples the command pins on every rising clock edge. It decodes each command and tracks what every bank is doing, and it counts down the minimum spacings that the device needs between commands. If a command cannot legally be sent in the current bank state, or arrives too soon after an earlier command, the guard emits a one-cycle error pulse. The pulse carries a class code and the bank concerned.

A flagged command is treated as if the device never acted on it, so bank state is not changed by it. Every spacing is a parameter in clock cycles. The current state of every bank is available on a packed output so that a scoreboard or a debug probe can follow it.

Top module: `ddr_cmd_guard`

## Requirements
- R1: A command is taken only on an edge where `cmd_clk_en` is 1 and `cmd_sel_n` is 0. It is decoded from {`cmd_row_n`,`cmd_col_n`,`cmd_wr_n`} as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register write (either register, chosen by bank bit 0), 110 burst stop, 111 no-op. Any other edge is a no-op, which changes no state and raises no error.
- R2: After synchronous reset, all banks report idle, no error is raised, and all spacing counters are clear, so an activate on the first edge after reset is legal.
- R3: Bank i reports its state on `bank_state[3i+2:3i]` with these codes: 0 idle, 1 opening, 2 open, 3 read burst with auto-precharge, 4 write burst with auto-precharge, 5 closing. After an activate the bank is opening for T_RCD-1 cycles and then open.
- R4: An error is reported in the cycle after the offending edge. `err_valid` is 1 for that one cycle, `err_code` holds 1 (illegal state), 2 (spacing), 3 (refresh while not all idle) or 4 (mode write while not all idle), and `err_bank` names the bank. A flagged command has no effect on any bank. When `err_valid` is 0, `err_code` is 0.
- R5: An activate to a bank that is not idle is an illegal-state error.
- R6: A read or write to a bank that is idle, closing or in an auto-precharge burst is an illegal-state error. A read or write to an opening bank (fewer than T_RCD cycles after its activate) is a spacing error.
- R7: `cmd_flag` set on a read or write selects auto-precharge. After a read with auto-precharge the bank reports code 3 for BURST_CYC cycles. After a write with auto-precharge it reports code 4 for BURST_CYC+T_WR cycles. In both cases it then reports closing for T_RP-1 cycles and then idle.
- R8: `cmd_flag` set on a precharge targets all banks; clear targets `cmd_bank` only. A precharge to an idle or closing bank is a legal no-op. A precharge to an opening bank or to an auto-precharge bank is an illegal-state error. A legal precharge of an open bank makes it closing for T_RP-1 cycles. If any targeted bank errs, no bank changes and `err_bank` is the lowest such bank.
- R9: A precharge of an open bank is a spacing error if it comes fewer than T_RAS cycles after that bank's activate, or fewer than BURST_CYC+T_WR cycles after a plain write to it.
- R10: An activate to an idle bank is a spacing error if it comes fewer than T_RC cycles after that bank's previous activate, or fewer than T_RRD cycles after an activate to any bank.
- R11: A refresh or mode-register write while any bank is not idle raises code 3 or code 4 respectively, with `err_bank` the lowest non-idle bank.
- R12: Any command other than a no-op is a spacing error, with `err_bank` equal to `cmd_bank`, if it comes fewer than T_RFC cycles after an accepted refresh or fewer than T_MRD cycles after an accepted mode-register write.
- R13: When a command breaks both a state rule and a spacing rule, it is reported as an illegal-state error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; pins sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_clk_en | input | 1 | Clock-enable pin level; 0 means no command is taken |
| cmd_sel_n | input | 1 | Chip select, active low |
| cmd_row_n | input | 1 | Row strobe, active low |
| cmd_col_n | input | 1 | Column strobe, active low |
| cmd_wr_n | input | 1 | Write enable, active low |
| cmd_bank | input | BA_W | Bank address |
| cmd_flag | input | 1 | Address bit 10: auto-precharge on read/write, all banks on precharge |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 3 | Error class (1 to 4) |
| err_bank | output | BA_W | Bank the error refers to |
| bank_state | output | 3*2**BA_W | Packed per-bank state codes |

## Verification
The bench sweeps the gap between each governing command and the command it gates across the boundary, one cycle at a time. A counter loaded with the spacing instead of spacing-1 would flag the first legal cycle, and one loaded too low would accept the last illegal one. The auto-precharge timelines are checked cycle by cycle, which exposes a burst or recovery phase that is one cycle short. All-bank precharge is checked with a single bank still inside its minimum open time, which catches a design that closes the other banks anyway or blames the wrong bank. The bench also checks deselected and clock-disabled edges, a refresh or mode write while a bank is busy, and commands that break two rules at once. These catch a decoder that ignores the select pins, a wrong lowest-busy-bank report, and a reversed error priority.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_ACT = 3'd1,
    C_RD  = 3'd2,
    C_WR  = 3'd3,
    C_PRE = 3'd4,
    C_REF = 3'd5,
    C_MRS = 3'd6,
    C_BST = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE    = 3'd0,
    B_OPENING = 3'd1,
    B_OPEN    = 3'd2,
    B_RDAP    = 3'd3,
    B_WRAP    = 3'd4,
    B_CLOSING = 3'd5
  } bank_e;

  typedef enum logic [2:0] {
    E_NONE     = 3'd0,
    E_STATE    = 3'd1,
    E_TIMING   = 3'd2,
    E_REF_BUSY = 3'd3,
    E_MRS_BUSY = 3'd4
  } err_e;

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // width of a down-counter able to hold v
  function automatic int cnt_width(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_guard_pkg::*;
(
  input  logic clk_en,
  input  logic sel_n,
  input  logic row_n,
  input  logic col_n,
  input  logic wr_n,
  input  logic flag,
  output cmd_e op,
  output logic auto_pre,
  output logic all_banks
);

  always_comb begin
    op = C_NOP;
    if (clk_en && !sel_n) begin
      case ({row_n, col_n, wr_n})
        3'b011:  op = C_ACT;
        3'b101:  op = C_RD;
        3'b100:  op = C_WR;
        3'b010:  op = C_PRE;
        3'b001:  op = C_REF;
        3'b000:  op = C_MRS;
        3'b110:  op = C_BST;
        default: op = C_NOP;
      endcase
    end
  end

  assign auto_pre  = flag && (op == C_RD || op == C_WR);
  assign all_banks = flag && (op == C_PRE);

endmodule

// File: rtl/ddr_gap_timers.sv
module ddr_gap_timers
  import ddr_guard_pkg::*;
#(
  parameter int T_RRD = 2,
  parameter int T_RFC = 14,
  parameter int T_MRD = 2
) (
  input  logic clk,
  input  logic rst,
  input  cmd_e op,
  input  logic take,
  output logic rrd_busy,
  output logic rfc_busy,
  output logic mrd_busy
);

  localparam int GMAX = cyc_max(cyc_max(T_RRD, T_RFC), T_MRD);
  localparam int GW   = cnt_width(GMAX);
  localparam logic [GW-1:0] LD_RRD = GW'(T_RRD - 1);
  localparam logic [GW-1:0] LD_RFC = GW'(T_RFC - 1);
  localparam logic [GW-1:0] LD_MRD = GW'(T_MRD - 1);

  logic [GW-1:0] rrd_q, rfc_q, mrd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_q <= '0;
      rfc_q <= '0;
      mrd_q <= '0;
    end else begin
      rrd_q <= (take && op == C_ACT) ? LD_RRD : ((rrd_q != '0) ? rrd_q - 1'b1 : rrd_q);
      rfc_q <= (take && op == C_REF) ? LD_RFC : ((rfc_q != '0) ? rfc_q - 1'b1 : rfc_q);
      mrd_q <= (take && op == C_MRS) ? LD_MRD : ((mrd_q != '0) ? mrd_q - 1'b1 : mrd_q);
    end
  end

  assign rrd_busy = (rrd_q != '0);
  assign rfc_busy = (rfc_q != '0);
  assign mrd_busy = (mrd_q != '0);

  p_refresh_gate_r12: assert property (@(posedge clk) disable iff (rst)
    (T_RFC > 1 && take && op == C_REF) |=> rfc_busy);

  p_mode_gate_r12: assert property (@(posedge clk) disable iff (rst)
    (T_MRD > 1 && take && op == C_MRS) |=> mrd_busy);

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_guard_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RC      = 11,
  parameter int T_RP      = 3,
  parameter int BURST_CYC = 2,
  parameter int T_WR      = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  cmd_e  op,
  input  logic  auto_pre,
  input  logic  take,
  output bank_e state,
  output logic  bad_state,
  output logic  bad_timing
);

  localparam int LD_MAX = cyc_max(cyc_max(T_RC, T_RAS), cyc_max(BURST_CYC + T_WR, T_RP));
  localparam int CW     = cnt_width(LD_MAX);
  localparam logic [CW-1:0] LD_RCD  = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RC   = CW'(T_RC - 1);
  localparam logic [CW-1:0] LD_RAS  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RDAP = CW'(BURST_CYC);
  localparam logic [CW-1:0] LD_WRAP = CW'(BURST_CYC + T_WR);
  localparam logic [CW-1:0] LD_WREC = CW'(BURST_CYC + T_WR - 1);
  localparam bank_e AFTER_ACT = (T_RCD > 1) ? B_OPENING : B_OPEN;
  localparam bank_e AFTER_PRE = (T_RP > 1) ? B_CLOSING : B_IDLE;

  bank_e         st_q, st_d;
  logic [CW-1:0] phase_q, phase_d;   // time left in a timed state
  logic [CW-1:0] rc_q, rc_d;         // same-bank activate spacing
  logic [CW-1:0] ras_q, ras_d;       // activate to precharge
  logic [CW-1:0] wrec_q, wrec_d;     // write to precharge

  function automatic logic [CW-1:0] dec_sat(input logic [CW-1:0] v);
    return (v != '0) ? v - 1'b1 : v;
  endfunction

  // verdict for the command on the pins, as seen by this bank
  always_comb begin
    bad_state  = 1'b0;
    bad_timing = 1'b0;
    case (op)
      C_ACT: begin
        bad_state  = (st_q != B_IDLE);
        bad_timing = (rc_q != '0);
      end
      C_RD, C_WR: begin
        bad_state  = (st_q inside {B_IDLE, B_CLOSING, B_RDAP, B_WRAP});
        bad_timing = (st_q == B_OPENING);
      end
      C_PRE: begin
        bad_state  = (st_q inside {B_OPENING, B_RDAP, B_WRAP});
        bad_timing = (st_q == B_OPEN) && ((ras_q != '0) || (wrec_q != '0));
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    phase_d = dec_sat(phase_q);
    rc_d    = dec_sat(rc_q);
    ras_d   = dec_sat(ras_q);
    wrec_d  = dec_sat(wrec_q);
    case (st_q)
      B_OPENING: if (phase_q <= 1) st_d = B_OPEN;
      B_RDAP, B_WRAP: if (phase_q <= 1) begin
        st_d    = AFTER_PRE;
        phase_d = LD_RP;
      end
      B_CLOSING: if (phase_q <= 1) st_d = B_IDLE;
      default: ;
    endcase
    if (take) begin
      case (op)
        C_ACT: begin
          st_d    = AFTER_ACT;
          phase_d = LD_RCD;
          rc_d    = LD_RC;
          ras_d   = LD_RAS;
          wrec_d  = '0;
        end
        C_RD: if (auto_pre) begin
          st_d    = B_RDAP;
          phase_d = LD_RDAP;
        end
        C_WR: begin
          if (auto_pre) begin
            st_d    = B_WRAP;
            phase_d = LD_WRAP;
          end else begin
            wrec_d = LD_WREC;
          end
        end
        C_PRE: if (st_q == B_OPEN) begin
          st_d    = AFTER_PRE;
          phase_d = LD_RP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= B_IDLE;
      phase_q <= '0;
      rc_q    <= '0;
      ras_q   <= '0;
      wrec_q  <= '0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
      rc_q    <= rc_d;
      ras_q   <= ras_d;
      wrec_q  <= wrec_d;
    end
  end

  assign state = st_q;

  p_opening_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == B_OPENING) |=> (st_q inside {B_OPENING, B_OPEN}));

  p_closing_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == B_CLOSING) |=> (st_q inside {B_CLOSING, B_IDLE}));

  p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == B_IDLE && !(take && op == C_ACT)) |=> (st_q == B_IDLE));

endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
  import ddr_guard_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RC      = 11,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_RFC     = 14,
  parameter int T_MRD     = 2,
  parameter int BURST_CYC = 2,
  parameter int T_WR      = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_clk_en,
  input  logic                      cmd_sel_n,
  input  logic                      cmd_row_n,
  input  logic                      cmd_col_n,
  input  logic                      cmd_wr_n,
  input  logic [BA_W-1:0]           cmd_bank,
  input  logic                      cmd_flag,
  output logic                      err_valid,
  output logic [2:0]                err_code,
  output logic [BA_W-1:0]           err_bank,
  output logic [3*(1<<BA_W)-1:0]    bank_state
);

  localparam int NBANK = 1 << BA_W;

  cmd_e            op;
  logic            auto_pre, all_banks;
  logic            commit;
  logic            rrd_busy, rfc_busy, mrd_busy, gate;
  logic [NBANK-1:0] sel, bad_s, bad_t;
  bank_e           st [NBANK];
  logic            all_idle;
  logic [BA_W-1:0] first_busy;
  err_e            code;
  logic [BA_W-1:0] eb;

  ddr_cmd_decode u_dec (
    .clk_en    (cmd_clk_en),
    .sel_n     (cmd_sel_n),
    .row_n     (cmd_row_n),
    .col_n     (cmd_col_n),
    .wr_n      (cmd_wr_n),
    .flag      (cmd_flag),
    .op        (op),
    .auto_pre  (auto_pre),
    .all_banks (all_banks)
  );

  ddr_gap_timers #(.T_RRD(T_RRD), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .take     (commit),
    .rrd_busy (rrd_busy),
    .rfc_busy (rfc_busy),
    .mrd_busy (mrd_busy)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign sel[i] = all_banks || (cmd_bank == BA_W'(i));
    ddr_bank_track #(
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
      .BURST_CYC(BURST_CYC), .T_WR(T_WR)
    ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .op         (op),
      .auto_pre   (auto_pre),
      .take       (commit && sel[i]),
      .state      (st[i]),
      .bad_state  (bad_s[i]),
      .bad_timing (bad_t[i])
    );
    assign bank_state[3*i +: 3] = st[i];
  end

  // lowest bank that is not idle
  always_comb begin
    all_idle   = 1'b1;
    first_busy = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (st[i] != B_IDLE) begin
        all_idle   = 1'b0;
        first_busy = BA_W'(i);
      end
    end
  end

  assign gate = rfc_busy || mrd_busy;

  // classify the command; state classes outrank spacing
  always_comb begin
    code = E_NONE;
    eb   = cmd_bank;
    case (op)
      C_NOP: ;
      C_REF, C_MRS: begin
        if (!all_idle) begin
          code = (op == C_REF) ? E_REF_BUSY : E_MRS_BUSY;
          eb   = first_busy;
        end else if (gate) begin
          code = E_TIMING;
        end
      end
      C_BST: if (gate) code = E_TIMING;
      default: begin
        if (all_banks) begin
          for (int i = NBANK - 1; i >= 0; i--)
            if (bad_t[i]) begin
              code = E_TIMING;
              eb   = BA_W'(i);
            end
          for (int i = NBANK - 1; i >= 0; i--)
            if (bad_s[i]) begin
              code = E_STATE;
              eb   = BA_W'(i);
            end
          if (code == E_NONE && gate) code = E_TIMING;
        end else if (bad_s[cmd_bank]) begin
          code = E_STATE;
        end else if (bad_t[cmd_bank] || gate || (op == C_ACT && rrd_busy)) begin
          code = E_TIMING;
        end
      end
    endcase
  end

  assign commit = (op != C_NOP) && (code == E_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_code  <= 3'd0;
      err_bank  <= '0;
    end else begin
      err_valid <= (code != E_NONE);
      err_code  <= code;
      err_bank  <= (code != E_NONE) ? eb : '0;
    end
  end

  p_err_has_code_r4: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code != 3'd0 && err_code <= 3'd4));

  p_quiet_code_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> (err_code == 3'd0));

  p_ref_needs_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (op == C_REF && !all_idle) |=> (err_valid && err_code == 3'd3));

  p_mrs_needs_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (op == C_MRS && !all_idle) |=> (err_valid && err_code == 3'd4));

endmodule

// File: tb/ddr_cmd_guard_test.sv
`timescale 1ns/1ps
module ddr_cmd_guard_test;

  localparam int T_RCD = 3, T_RAS = 8, T_RC = 13, T_RP = 3, T_RRD = 2;
  localparam int T_RFC = 14, T_MRD = 2, BC = 2, T_WR = 3;

  localparam logic [2:0] OP_ACT = 3'b011, OP_RD = 3'b101, OP_WR = 3'b100;
  localparam logic [2:0] OP_PRE = 3'b010, OP_REF = 3'b001, OP_MRS = 3'b000;
  localparam logic [2:0] OP_BST = 3'b110, OP_NOP = 3'b111;

  logic clk = 1'b0, rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, r_n = 1'b1, c_n = 1'b1, w_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic flag = 1'b0;
  logic err_valid;
  logic [2:0] err_code;
  logic [1:0] err_bank;
  logic [11:0] bank_state;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_guard #(
    .BA_W(2), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
    .T_RRD(T_RRD), .T_RFC(T_RFC), .T_MRD(T_MRD), .BURST_CYC(BC), .T_WR(T_WR)
  ) uut (
    .clk(clk), .rst(rst), .cmd_clk_en(cke), .cmd_sel_n(cs_n),
    .cmd_row_n(r_n), .cmd_col_n(c_n), .cmd_wr_n(w_n),
    .cmd_bank(ba), .cmd_flag(flag),
    .err_valid(err_valid), .err_code(err_code), .err_bank(err_bank),
    .bank_state(bank_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int bst(input int b);
    return int'(bank_state[3*b +: 3]);
  endfunction

  // one edge with the given pins; results sampled 1 ns after the edge
  task automatic raw(input logic en, input logic s_n, input logic [2:0] rcw,
                     input int b, input logic f);
    @(negedge clk);
    cke = en; cs_n = s_n; {r_n, c_n, w_n} = rcw; ba = 2'(b); flag = f;
    @(posedge clk);
    #1;
    cke = 1'b1; cs_n = 1'b1; {r_n, c_n, w_n} = OP_NOP; flag = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] rcw, input int b, input logic f);
    raw(1'b1, 1'b0, rcw, b, f);
  endtask

  task automatic nops(input int n);
    for (int k = 0; k < n; k++) cmd(OP_NOP, 0, 1'b0);
  endtask

  task automatic expect_err(input string tag, input int code, input int b);
    chk({tag, " valid"}, int'(err_valid), (code != 0) ? 1 : 0);
    chk({tag, " code"}, int'(err_code), code);
    if (code != 0) chk({tag, " bank"}, int'(err_bank), b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R2: reset state, then immediate activate is legal
    do_reset();
    #1;
    for (int b = 0; b < 4; b++) chk("R2 idle after reset", bst(b), 0);
    chk("R2 no error after reset", int'(err_valid), 0);
    cmd(OP_ACT, 0, 1'b0);
    expect_err("R2 first act", 0, 0);

    // R3: opening for T_RCD-1 samples, then open
    do_reset();
    cmd(OP_ACT, 1, 1'b0);
    for (int j = 0; j < 5; j++) begin
      chk("R3 opening/open", bst(1), (j < T_RCD - 1) ? 1 : 2);
      nops(1);
    end

    // R6: read/write gap after activate
    for (int d = 1; d <= 4; d++) begin
      do_reset();
      cmd(OP_ACT, 2, 1'b0);
      nops(d - 1);
      cmd((d % 2) ? OP_WR : OP_RD, 2, 1'b0);
      expect_err("R6 act->rd/wr", (d < T_RCD) ? 2 : 0, 2);
    end

    // R9, R13: precharge gap after activate
    for (int d = 1; d <= 9; d++) begin
      do_reset();
      cmd(OP_ACT, 0, 1'b0);
      nops(d - 1);
      cmd(OP_PRE, 0, 1'b0);
      expect_err("R9 act->pre", (d < T_RCD) ? 1 : (d < T_RAS) ? 2 : 0, 0);
      chk("R9 state after pre", bst(0), (d < T_RCD) ? ((d + 1 < T_RCD) ? 1 : 2) :
                                       (d < T_RAS) ? 2 : 5);
    end

    // R9: write recovery before precharge
    for (int d = 1; d <= 6; d++) begin
      do_reset();
      cmd(OP_ACT, 3, 1'b0);
      nops(7);
      cmd(OP_WR, 3, 1'b0);
      nops(d - 1);
      cmd(OP_PRE, 3, 1'b0);
      expect_err("R9 wr->pre", (d < BC + T_WR) ? 2 : 0, 3);
    end

    // R10: activate to another bank
    for (int d = 1; d <= 3; d++) begin
      do_reset();
      cmd(OP_ACT, 0, 1'b0);
      nops(d - 1);
      cmd(OP_ACT, 1, 1'b0);
      expect_err("R10 rrd", (d < T_RRD) ? 2 : 0, 1);
    end

    // R10, R5: activate-precharge-activate on one bank
    for (int d = 9; d <= 14; d++) begin
      do_reset();
      cmd(OP_ACT, 1, 1'b0);
      nops(7);
      cmd(OP_PRE, 1, 1'b0);
      nops(d - 9);
      cmd(OP_ACT, 1, 1'b0);
      expect_err("R10 act-pre-act", (d - 8 < T_RP) ? 1 : (d < T_RC) ? 2 : 0, 1);
    end

    // R5, R13: second activate to an opening bank is a state error
    do_reset();
    cmd(OP_ACT, 0, 1'b0);
    cmd(OP_ACT, 0, 1'b0);
    expect_err("R13 act on opening", 1, 0);

    // R12: refresh gap
    for (int d = 1; d <= 15; d++) begin
      do_reset();
      cmd(OP_REF, 0, 1'b0);
      nops(d - 1);
      cmd(OP_ACT, d % 4, 1'b0);
      expect_err("R12 ref->act", (d < T_RFC) ? 2 : 0, d % 4);
    end

    // R12: mode-register gap (both registers), burst stop gated too
    for (int d = 1; d <= 3; d++) begin
      do_reset();
      cmd(OP_MRS, d % 2, 1'b0);
      nops(d - 1);
      cmd(OP_BST, 3, 1'b0);
      expect_err("R12 mrs->bst", (d < T_MRD) ? 2 : 0, 3);
    end

    // R11: refresh / mode write while a bank is busy
    do_reset();
    cmd(OP_ACT, 2, 1'b0);
    nops(2);
    cmd(OP_REF, 0, 1'b0);
    expect_err("R11 ref busy", 3, 2);
    cmd(OP_MRS, 1, 1'b0);
    expect_err("R11 mrs busy", 4, 2);
    cmd(OP_ACT, 1, 1'b0);
    expect_err("R11 act b1", 0, 1);
    cmd(OP_REF, 3, 1'b0);
    expect_err("R11 lowest busy", 3, 1);

    // R7: read with auto-precharge timeline
    do_reset();
    cmd(OP_ACT, 0, 1'b0);
    nops(7);
    cmd(OP_RD, 0, 1'b1);
    expect_err("R7 rda accept", 0, 0);
    for (int j = 0; j < 6; j++) begin
      chk("R7 rda timeline", bst(0), (j < BC) ? 3 : (j < BC + T_RP - 1) ? 5 : 0);
      if (j == 0) begin
        cmd(OP_RD, 0, 1'b0);
        expect_err("R6 rd during ap", 1, 0);
      end else nops(1);
    end

    // R7: write with auto-precharge timeline
    do_reset();
    cmd(OP_ACT, 1, 1'b0);
    nops(7);
    cmd(OP_WR, 1, 1'b1);
    for (int j = 0; j < 9; j++) begin
      chk("R7 wra timeline", bst(1),
          (j < BC + T_WR) ? 4 : (j < BC + T_WR + T_RP - 1) ? 5 : 0);
      nops(1);
    end

    // R5, R7: activate after read with auto-precharge
    for (int d = 1; d <= 6; d++) begin
      do_reset();
      cmd(OP_ACT, 0, 1'b0);
      nops(7);
      cmd(OP_RD, 0, 1'b1);
      nops(d - 1);
      cmd(OP_ACT, 0, 1'b0);
      expect_err("R5 act after rda",
                 (d < BC + T_RP) ? 1 : (8 + d < T_RC) ? 2 : 0, 0);
    end

    // R8: all-bank precharge
    do_reset();
    cmd(OP_ACT, 0, 1'b0);
    nops(1);
    cmd(OP_ACT, 1, 1'b0);
    nops(6);
    cmd(OP_PRE, 3, 1'b1);
    expect_err("R8 pre-all timing", 2, 1);
    chk("R8 b0 unchanged", bst(0), 2);
    chk("R8 b1 unchanged", bst(1), 2);
    nops(1);
    cmd(OP_PRE, 2, 1'b1);
    expect_err("R8 pre-all ok", 0, 0);
    chk("R8 b0 closing", bst(0), 5);
    chk("R8 b1 closing", bst(1), 5);
    chk("R8 b2 idle", bst(2), 0);
    cmd(OP_PRE, 2, 1'b0);
    expect_err("R8 pre idle bank", 0, 2);
    cmd(OP_PRE, 0, 1'b0);
    expect_err("R8 pre closing bank", 0, 0);

    // R8: single-bank precharge leaves other banks open
    do_reset();
    cmd(OP_ACT, 3, 1'b0);
    nops(1);
    cmd(OP_ACT, 2, 1'b0);
    nops(8);
    cmd(OP_PRE, 3, 1'b0);
    expect_err("R8 single pre", 0, 3);
    chk("R8 target closing", bst(3), 5);
    chk("R8 other open", bst(2), 2);
    cmd(OP_ACT, 0, 1'b0);
    nops(1);
    cmd(OP_PRE, 0, 1'b1);
    expect_err("R8 pre-all on opening", 1, 0);

    // R1: deselected and clock-disabled edges are ignored
    do_reset();
    raw(1'b1, 1'b1, OP_RD, 1, 1'b0);
    expect_err("R1 deselect rd", 0, 0);
    raw(1'b0, 1'b0, OP_ACT, 1, 1'b0);
    expect_err("R1 cke low act", 0, 0);
    chk("R1 bank still idle", bst(1), 0);
    raw(1'b1, 1'b1, OP_ACT, 2, 1'b0);
    chk("R1 deselect act idle", bst(2), 0);

    // R4: one-cycle pulse, dropped command
    do_reset();
    cmd(OP_RD, 1, 1'b0);
    expect_err("R4 rd idle", 1, 1);
    chk("R4 state unchanged", bst(1), 0);
    nops(1);
    expect_err("R4 pulse ends", 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule